// File: doc/BRIEF.md
# Scan Register with Held Functional Outputs

A bank of `N` mux-scan flip-flops joined into a single serial scan path. In mission mode (test-enable low) every cell loads its own bit of the parallel functional input on the clock edge. In shift mode (test-enable high) every cell instead loads the value of the cell before it. Cell 0 loads the serial input, and the last cell drives the serial output. The scan select multiplexer sits in front of each flip-flop, so it adds one mux delay to the functional path.

Each cell also has a hold register on its functional output. While the hold control is low, this register takes the same value the flip-flop captures on the same edge, so the output tracks the register. While hold is high, the functional outputs stay frozen and the flip-flops keep shifting underneath. This stops the downstream logic from toggling during scan load and unload, which cuts switching power and isolates downstream parts during test. The serial output always taps the flip-flop, never the held copy, so unloading works whether or not hold is set.

Top module: `scan_hold_reg`

## Requirements
- R1: While `rst_n` is low, `func_q` is all zeros and `scan_out` is 0, with no clock edge needed.
- R2: On an edge with `test_en` = 0, cell i loads `func_d[i]`.
- R3: On an edge with `test_en` = 1, cell 0 loads `scan_in` and cell i (i > 0) loads the previous contents of cell i-1.
- R4: `scan_out` always shows the flip-flop contents of cell N-1, whatever the value of `hold`.
- R5: On an edge with `hold` = 1, `func_q` keeps its value, whatever the flip-flops load.
- R6: On an edge with `hold` = 0, `func_q[i]` takes the same value that cell i loads on that edge.
- R7: After a capture of a word P, `scan_out` shows P[N-1], P[N-2], …, P[0] before shift edges 1 to N, that is, last cell first.
- R8: Dropping `hold` after a held period makes `func_q` equal to the cell contents from the next edge onward, which discards the frozen value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_en | input | 1 | 1 = shift the serial path, 0 = capture `func_d` |
| hold | input | 1 | 1 = freeze `func_q` |
| func_d | input | N | Parallel functional data |
| scan_in | input | 1 | Serial input to cell 0 |
| func_q | output | N | Held functional outputs |
| scan_out | output | 1 | Serial output from cell N-1 |

## Verification
The hardest case to reach is a clear divergence between the flip-flops and the held outputs. That divergence only exists after a capture with hold low, followed by a run of shifts, or held captures, with hold high. The stimulus therefore loads a known word and raises hold. It then shifts a full N cycles, checking the serial output order and the frozen outputs on each cycle. It also performs a held functional capture and then releases hold. After the release, the outputs must jump to the register contents in a single edge.

// File: rtl/scan_hold_reg.sv
module scan_hold_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_en,
  input  logic         hold,
  input  logic [N-1:0] func_d,
  input  logic         scan_in,
  output logic [N-1:0] func_q,
  output logic         scan_out
);

  logic [N-1:0] cells;
  logic [N-1:0] held;
  logic [N-1:0] shift_src;
  logic [N-1:0] nxt;

  generate
    if (N == 1) begin : g_single
      assign shift_src = scan_in;
    end else begin : g_chain
      assign shift_src = {cells[N-2:0], scan_in};
    end
  endgenerate

  assign nxt = test_en ? shift_src : func_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells <= '0;
      held  <= '0;
    end else begin
      cells <= nxt;
      if (!hold) held <= nxt;
    end
  end

  assign func_q   = held;
  assign scan_out = cells[N-1];

endmodule

// File: rtl/scan_hold_chk.sv
module scan_hold_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         test_en,
  input logic         hold,
  input logic [N-1:0] func_d,
  input logic         scan_in,
  input logic [N-1:0] func_q,
  input logic         scan_out,
  input logic [N-1:0] cells
);

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (func_q == '0 && scan_out == 1'b0);
    end
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> cells == $past(func_d));

  assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |=> cells[0] == $past(scan_in));

  generate
    if (N > 1) begin : g_multi
      assert_shift_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        test_en |=> cells[N-1:1] == $past(cells[N-2:0]));
      assert_serial_tap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        test_en |=> scan_out == $past(cells[N-2]));
    end
  endgenerate

  assert_hold_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(func_q));

  assert_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> func_q == cells);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |=> func_q == cells);

endmodule

bind scan_hold_reg scan_hold_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_en(test_en), .hold(hold),
  .func_d(func_d), .scan_in(scan_in), .func_q(func_q),
  .scan_out(scan_out), .cells(cells)
);

// File: tb/sim_scan_hold_reg.sv
`timescale 1ns/1ps
module sim_scan_hold_reg;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_en = 1'b0;
  logic hold = 1'b0;
  logic [N-1:0] func_d = '0;
  logic scan_in = 1'b0;
  logic [N-1:0] func_q;
  logic scan_out;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string tag = "R1";

  bit chain[$];
  logic [N-1:0] m_held = '0;

  always #2.5 clk = ~clk;

  scan_hold_reg #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .hold(hold),
    .func_d(func_d), .scan_in(scan_in), .func_q(func_q), .scan_out(scan_out)
  );

  initial begin
    for (int i = 0; i < N; i++) chain.push_back(1'b0);
  end

  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      if (test_en) begin
        chain.push_front(scan_in);
        void'(chain.pop_back());
      end else begin
        chain.delete();
        for (int i = 0; i < N; i++) chain.push_back(func_d[i]);
      end
      if (!hold) for (int i = 0; i < N; i++) m_held[i] = chain[i];
    end
  end

  task automatic check_bit(string req, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic compare();
    compared++;
    if (func_q !== m_held) begin
      mismatched++;
      $display("FAIL %s func_q: got %h expected %h at cycle %0d", tag, func_q, m_held, cycles);
    end
    check_bit({tag, " R4 scan_out"}, scan_out, chain[N-1]);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    logic [N-1:0] pat;
    // R1: reset state before and after the first edges
    @(negedge clk); compare();
    @(negedge clk); compare();
    rst_n = 1'b1;

    // R2 and R6: captures with hold low
    tag = "R2/R6";
    foreach (func_d[i]) func_d[i] = i[0];
    tick();
    func_d = 8'hA5; tick();
    func_d = 8'h3C; tick();
    for (int k = 0; k < 4; k++) begin func_d = 8'($urandom); tick(); end

    // R3: shifting with hold low, outputs follow
    tag = "R3";
    test_en = 1'b1;
    for (int k = 0; k < 12; k++) begin scan_in = 1'($urandom); tick(); end

    // R7 and R5: capture known word, freeze, unload N bits
    tag = "R6";
    test_en = 1'b0; pat = 8'b1101_0010; func_d = pat; tick();
    tag = "R5";
    hold = 1'b1; test_en = 1'b1;
    for (int k = 0; k < N; k++) begin
      check_bit("R7 order", scan_out, pat[N-1-k]);
      scan_in = 1'($urandom); func_d = 8'($urandom);
      tick();
    end

    // R5 and R4: held functional capture, serial output sees new flops
    test_en = 1'b0; func_d = 8'h81; tick();
    check_bit("R4 held capture", scan_out, 1'b1);
    check_bit("R5 frozen", func_q[0], pat[0]);

    // R8: release hold
    tag = "R8";
    hold = 1'b0; func_d = 8'h5A; tick();
    compared++;
    if (func_q !== 8'h5A) begin
      mismatched++;
      $display("FAIL R8 release: got %h expected %h", func_q, 8'h5A);
    end

    // mixed random traffic
    tag = "R3/R5/R6";
    for (int k = 0; k < 60; k++) begin
      test_en = 1'($urandom); hold = 1'($urandom);
      scan_in = 1'($urandom); func_d = 8'($urandom);
      tick();
    end

    // R1: asynchronous reset mid-run
    tag = "R1";
    @(posedge clk); #1;
    rst_n = 1'b0;
    chain.delete();
    for (int i = 0; i < N; i++) chain.push_back(1'b0);
    m_held = '0;
    #0.5;
    compare();
    @(negedge clk); compare();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule